// File: doc/BRIEF.md
# Counter-Based Leaf Position Map

This unit keeps the block-to-leaf mapping for a tree-structured oblivious memory controller without storing a random leaf per block. Blocks are grouped four at a time. Each group holds one wide shared counter and a narrow private counter for every block in the group. The leaf of a block is a keyed mix of four values: the shared counter, the group number, the private counter and the block's slot in the group. Changing a counter therefore moves the block to a fresh pseudorandom leaf.

A request carries a block address and a remap flag. Two cycles later the unit answers with the block's current leaf, and with the leaf it holds after the request. On a remap the private counter steps up by one. If that counter is already at its maximum, the shared counter steps up instead and all private counters in the group return to zero. A pulse then tells the controller that every block in that group has a new leaf. The counters only ever move forward, so a counter tuple is never mixed twice under one key. The mixing key is taken from an input port while reset is held.

Top module: `ctr_posmap`

## Requirements
- R1: While reset (rstN low) is held, all counters clear to zero, the key is copied from keyIn, and rspValid and groupRemap are low. keyIn is ignored once reset is released.
- R2: Each cycle with reqValid high produces exactly one cycle of rspValid, two rising edges later. rspValid is never high otherwise. Requests may arrive every cycle.
- R3: A request with reqRemap low returns newLeaf equal to oldLeaf and changes no counter.
- R4: A remap whose private counter is below 7 raises that counter by one. newLeaf is the leaf for the raised counter.
- R5: A remap whose private counter equals 7 raises the group counter by one and clears all four private counters of that group. groupRemap is high in the response cycle.
- R6: groupRemap is high only together with rspValid, and only for the overflowing remap of R5.
- R7: A request changes no counter outside the requested group, and changes no private counter of another block in the group unless R5 applies.
- R8: A request sees the counter updates of every earlier request, including the one accepted in the cycle before it.
- R9: Address bits [5:2] select the group and bits [1:0] select the slot. The tuple is the 32-bit word {7'b0, groupCtr[15:0], group[3:0], privCtr[2:0], slot[1:0]}. The mix sets v = tuple ^ key, then runs three rounds of: v = rotate-left(v,7) + key; v = v ^ (v >> 11). The leaf is v[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| keyIn | input | 32 | Mixing key, sampled while reset is held |
| reqValid | input | 1 | Request strobe |
| reqAddr | input | 6 | Block address: group in [5:2], slot in [1:0] |
| reqRemap | input | 1 | Move the block to a new leaf |
| rspValid | output | 1 | Response strobe |
| oldLeaf | output | 8 | Leaf before the request |
| newLeaf | output | 8 | Leaf after the request |
| groupRemap | output | 1 | All blocks of the group moved |

## Verification
The properties assume that reqRemap is driven in the same cycle as reqValid and is meaningful only then. They also assume that reset is held for at least two cycles, so that no request from before reset reaches the response stage. The stimulus keeps reqValid low during reset and changes address and remap flag only together with the strobe. It issues far fewer than 2^16 overflows, so the group counter never wraps. Under that limit, the assumption that leaves never repeat their tuple holds.

// File: rtl/ctr_posmap_pkg.sv
package ctr_posmap_pkg;
  localparam int MIX_W = 32;

  typedef struct packed {
    logic capture;
    logic commit;
  } cpmStrobe_t;
endpackage

// File: rtl/ctr_posmap_ctrl.sv
module ctr_posmap_ctrl
  import ctr_posmap_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output cpmStrobe_t stb,
  output logic       rspValid
);
  logic stageQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageQ   <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      stageQ   <= reqValid;
      rspValid <= stageQ;
    end
  end

  always_comb begin
    stb.capture = reqValid;
    stb.commit  = stageQ;
  end
endmodule

// File: rtl/ctr_posmap_dp.sv
module ctr_posmap_dp
  import ctr_posmap_pkg::*;
#(
  parameter int GROUPS = 16,
  parameter int K      = 4,
  parameter int GC_W   = 16,
  parameter int IC_W   = 3,
  parameter int LEAF_W = 8,
  parameter int ROUNDS = 3,
  localparam int GRP_W  = $clog2(GROUPS),
  localparam int IDX_W  = $clog2(K),
  localparam int ADDR_W = GRP_W + IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MIX_W-1:0]  keyIn,
  input  cpmStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRemap,
  output logic [LEAF_W-1:0] oldLeaf,
  output logic [LEAF_W-1:0] newLeaf,
  output logic              groupRemap
);
  localparam int TUP_W = GC_W + GRP_W + IC_W + IDX_W;

  logic [MIX_W-1:0]  keyQ;
  logic [ADDR_W-1:0] addrQ;
  logic              remapQ;
  logic [GC_W-1:0]   gcArr [GROUPS];
  logic [IC_W-1:0]   icArr [GROUPS][K];

  logic [GRP_W-1:0]  grp;
  logic [IDX_W-1:0]  slot;
  logic [GC_W-1:0]   curGc, nextGc;
  logic [IC_W-1:0]   curIc, nextIc;
  logic              overflow;

  function automatic logic [LEAF_W-1:0] mixLeaf(
    input logic [MIX_W-1:0] key,
    input logic [GC_W-1:0]  gc,
    input logic [GRP_W-1:0] g,
    input logic [IC_W-1:0]  ic,
    input logic [IDX_W-1:0] s
  );
    logic [MIX_W-1:0] v;
    v = {{(MIX_W-TUP_W){1'b0}}, gc, g, ic, s} ^ key;
    for (int r = 0; r < ROUNDS; r++) begin
      v = {v[MIX_W-8:0], v[MIX_W-1:MIX_W-7]} + key;
      v = v ^ (v >> 11);
    end
    return v[LEAF_W-1:0];
  endfunction

  always_comb begin
    grp      = addrQ[ADDR_W-1:IDX_W];
    slot     = addrQ[IDX_W-1:0];
    curGc    = gcArr[grp];
    curIc    = icArr[grp][slot];
    overflow = remapQ && (curIc == {IC_W{1'b1}});
    nextGc   = overflow ? curGc + 1'b1 : curGc;
    if (overflow)    nextIc = '0;
    else if (remapQ) nextIc = curIc + 1'b1;
    else             nextIc = curIc;
  end

  // request capture stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      remapQ <= 1'b0;
      keyQ   <= keyIn;
    end else if (stb.capture) begin
      addrQ  <= reqAddr;
      remapQ <= reqRemap;
    end
  end

  // counter storage and response stage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int g = 0; g < GROUPS; g++) begin
        gcArr[g] <= '0;
        for (int b = 0; b < K; b++) icArr[g][b] <= '0;
      end
      oldLeaf    <= '0;
      newLeaf    <= '0;
      groupRemap <= 1'b0;
    end else begin
      groupRemap <= stb.commit && overflow;
      if (stb.commit) begin
        oldLeaf <= mixLeaf(keyQ, curGc, grp, curIc, slot);
        newLeaf <= mixLeaf(keyQ, nextGc, grp, nextIc, slot);
        if (overflow) begin
          gcArr[grp] <= nextGc;
          for (int b = 0; b < K; b++) icArr[grp][b] <= '0;
        end else if (remapQ) begin
          icArr[grp][slot] <= nextIc;
        end
      end
    end
  end
endmodule

// File: rtl/ctr_posmap.sv
module ctr_posmap
  import ctr_posmap_pkg::*;
#(
  parameter int GROUPS = 16,
  parameter int K      = 4,
  parameter int GC_W   = 16,
  parameter int IC_W   = 3,
  parameter int LEAF_W = 8,
  parameter int ROUNDS = 3,
  localparam int ADDR_W = $clog2(GROUPS) + $clog2(K)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       keyIn,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqRemap,
  output logic              rspValid,
  output logic [LEAF_W-1:0] oldLeaf,
  output logic [LEAF_W-1:0] newLeaf,
  output logic              groupRemap
);
  cpmStrobe_t stb;

  ctr_posmap_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .stb(stb), .rspValid(rspValid)
  );

  ctr_posmap_dp #(
    .GROUPS(GROUPS), .K(K), .GC_W(GC_W), .IC_W(IC_W), .LEAF_W(LEAF_W), .ROUNDS(ROUNDS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .stb(stb), .reqAddr(reqAddr),
    .reqRemap(reqRemap), .oldLeaf(oldLeaf), .newLeaf(newLeaf), .groupRemap(groupRemap)
  );
endmodule

// File: rtl/ctr_posmap_chk.sv
module ctr_posmap_chk #(
  parameter int LEAF_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqRemap,
  input logic              rspValid,
  input logic [LEAF_W-1:0] oldLeaf,
  input logic [LEAF_W-1:0] newLeaf,
  input logic              groupRemap
);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ##2 rspValid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid, 2));

  a_r3_lookup_keeps_leaf: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(reqRemap, 2)) |-> (newLeaf == oldLeaf));

  a_r6_pulse_with_rsp: assert property (@(posedge clk) disable iff (!rstN)
    groupRemap |-> rspValid);

  a_r6_pulse_needs_remap: assert property (@(posedge clk) disable iff (!rstN)
    groupRemap |-> $past(reqRemap, 2));

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    $past(!rstN) |-> (!rspValid && !groupRemap));
endmodule

bind ctr_posmap ctr_posmap_chk #(.LEAF_W(LEAF_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRemap(reqRemap),
  .rspValid(rspValid), .oldLeaf(oldLeaf), .newLeaf(newLeaf), .groupRemap(groupRemap)
);

// File: tb/ctr_posmap_tb_top.sv
module ctr_posmap_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] keyIn = 32'h5A17_C3E9;
  logic        reqValid = 1'b0;
  logic [5:0]  reqAddr = '0;
  logic        reqRemap = 1'b0;
  logic        rspValid, groupRemap;
  logic [7:0]  oldLeaf, newLeaf;

  localparam logic [31:0] KEY = 32'h5A17_C3E9;

  always #2 clk = ~clk;

  ctr_posmap dut_i (
    .clk(clk), .rstN(rstN), .keyIn(keyIn), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqRemap(reqRemap), .rspValid(rspValid), .oldLeaf(oldLeaf), .newLeaf(newLeaf),
    .groupRemap(groupRemap)
  );

  typedef struct {
    int         due;
    logic [7:0] oldL;
    logic [7:0] newL;
    logic       pulse;
    string      tag;
  } item_t;

  item_t      expQ[$];
  int         compared = 0;
  int         mismatched = 0;
  int         cyc = 0;
  bit         done = 0;
  logic [15:0] gcM [16];
  logic [2:0]  icM [16][4];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] refLeaf(logic [15:0] gc, int g, logic [2:0] ic, int s);
    logic [31:0] v;
    v = ({16'b0, gc} << 9) | (32'(g) << 5) | (32'(ic) << 2) | 32'(s);
    v = v ^ KEY;
    for (int r = 0; r < 3; r++) begin
      v = ((v << 7) | (v >> 25)) + KEY;
      v = v ^ (v >> 11);
    end
    return v[7:0];
  endfunction

  task automatic fail(string tag, string what, int act, int exp);
    mismatched++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  task automatic issue(int addr, bit remap, string tag);
    item_t it;
    int g, s;
    g = addr >> 2;
    s = addr & 3;
    it.oldL  = refLeaf(gcM[g], g, icM[g][s], s);
    it.pulse = remap && (icM[g][s] == 3'd7);
    if (it.pulse) begin
      gcM[g] = gcM[g] + 1;
      for (int b = 0; b < 4; b++) icM[g][b] = 3'd0;
    end else if (remap) begin
      icM[g][s] = icM[g][s] + 1;
    end
    it.newL = refLeaf(gcM[g], g, icM[g][s], s);
    it.tag  = tag;
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = 6'(addr);
    reqRemap = remap;
    it.due   = cyc + 2;
    expQ.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      reqRemap = 1'b0;
    end
  endtask

  // monitor: compares responses against the queue
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (rspValid) begin
        item_t it;
        compared++;
        if (expQ.size() == 0) fail("R2", "unexpected rspValid", 1, 0);
        else begin
          it = expQ.pop_front();
          if (it.due != cyc) fail("R2", "latency cycle", cyc, it.due);
          if (oldLeaf != it.oldL) fail(it.tag, "oldLeaf", oldLeaf, it.oldL);
          if (newLeaf != it.newL) fail(it.tag, "newLeaf", newLeaf, it.newL);
          if (groupRemap != it.pulse) fail({it.tag, "/R6"}, "groupRemap", groupRemap, it.pulse);
        end
      end else begin
        if (groupRemap) begin compared++; fail("R6", "pulse without rsp", 1, 0); end
        if (expQ.size() != 0 && expQ[0].due <= cyc) begin
          compared++;
          fail("R2", "missing rspValid", 0, 1);
          void'(expQ.pop_front());
        end
      end
    end
  end

  initial begin
    for (int g = 0; g < 16; g++) begin
      gcM[g] = '0;
      for (int b = 0; b < 4; b++) icM[g][b] = '0;
    end
    repeat (4) @(negedge clk);
    // R1: quiet outputs under reset
    compared++;
    if (rspValid || groupRemap || oldLeaf != 0 || newLeaf != 0)
      fail("R1", "outputs in reset", {rspValid, groupRemap, oldLeaf, newLeaf}, 0);
    rstN = 1'b1;
    keyIn = 32'hDEAD_BEEF; // R1: ignored after reset
    idle(2);
    compared++;
    if (rspValid) fail("R1", "rspValid after reset", 1, 0);

    // R1 R9: fresh leaves of several blocks, spread across groups
    issue(0, 0, "R1/R9");
    issue(1, 0, "R9");
    issue(2, 0, "R9");
    issue(63, 0, "R9");
    idle(3);
    issue(22, 0, "R9");
    idle(4);

    // R4 R8: back-to-back remaps of block 5
    for (int i = 0; i < 7; i++) issue(5, 1, "R4/R8");
    issue(5, 0, "R3");
    issue(5, 0, "R3");
    idle(2);
    // R7: neighbours untouched by private remaps
    issue(4, 0, "R7");
    issue(6, 0, "R7");
    // R5: overflow of block 5
    issue(5, 1, "R5");
    issue(4, 0, "R5");
    issue(7, 0, "R5");
    issue(5, 0, "R5");
    issue(9, 0, "R7");
    idle(4);

    // R5 R8: second overflow in group 3 driven through one slot, then neighbours
    for (int i = 0; i < 8; i++) issue(14, 1, "R4/R5");
    issue(14, 1, "R4");
    issue(12, 1, "R4");
    issue(13, 0, "R5");
    idle(1);
    issue(1, 1, "R7");
    issue(0, 0, "R7");
    idle(6);

    compared++;
    if (expQ.size() != 0) fail("R2", "responses outstanding", expQ.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule